// File: doc/BRIEF.md
# Framebuffer Dirty-Region Tracker

This block keeps track of which parts of a framebuffer the host has written since the last screen refresh. The framebuffer is divided into pages, and each page holds four 1024-pixel rows of the 8-bit index plane. In 24-bit colour mode the index plane has two wider companions: a direct-colour plane and a per-pixel control plane. Each of them spans four pages for every index page. A row group (four rows) counts as dirty when its index page is dirty. In 24-bit mode it is also dirty when any of the four matching pages in either wide plane is dirty.

A refresh scan steps through the row groups of the configured screen, one group per clock. For every maximal run of dirty groups it emits one full-width update span, given as a first row and a row count. After the last group it clears the flags between the lowest and the highest dirty group it found, then pulses a done strobe. Some host writes arrive while a scan is running. Those pages stay dirty for the following scan. An invalidate pulse marks every page of every plane, which forces a full redraw.

Top module: `fb_dirty_tracker`

## Requirements
- R1: After reset no flag is set: a scan emits no span, and no span or done strobe appears outside a scan.
- R2: A host write with plane code 0 to byte address A marks row group A>>12 dirty. The next scan emits a span whose first row is 4*(A>>12) and whose count is 4.
- R3: Adjacent dirty groups merge into one span. Separate runs produce separate spans, in ascending row order, each with a count of four times the run length.
- R4: Only groups below cfg_groups are scanned. A run that reaches the last configured group is emitted at the end of the scan.
- R5: With color24_en high, a write with plane code 1 (direct) or 2 (control) to page P marks group P>>2. With color24_en low, such writes produce no span.
- R6: A scan clears the flags it reported, so a second scan with no writes in between emits no span.
- R7: Flags of groups at or above cfg_groups survive a scan. They are reported once the screen is configured larger.
- R8: An invalidate pulse makes the next scan emit exactly one span, from row 0 with count 4*cfg_groups, in either colour mode. Afterwards the planes are clean.
- R9: A write during a scan to a group the scan has already passed is reported by the next scan.
- R10: scan_done is high for exactly one cycle, cfg_groups+1 cycles after the clock edge that samples scan_start. A scan_start pulse during a scan has no effect.
- R11: Writes with plane code 3, or with plane code 0 to a page at or above MAX_GROUPS, mark nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| color24_en | input | 1 | 24-bit mode: wide planes take part in dirtiness |
| cfg_groups | input | CW | Screen height in four-row groups (1..MAX_GROUPS) |
| wr_en | input | 1 | Host write strobe |
| wr_plane | input | 2 | Plane code: 0 index, 1 direct, 2 control, 3 none |
| wr_addr | input | ADDR_W | Byte address within the plane |
| invalidate | input | 1 | Mark every page of every plane dirty |
| scan_start | input | 1 | Begin a refresh scan (ignored while one runs) |
| span_valid | output | 1 | Span record present this cycle |
| span_row | output | RW | First row of the span |
| span_rows | output | RW | Number of rows in the span |
| scan_done | output | 1 | One-cycle end-of-scan strobe |

## Verification
A flag that is wrongly held shows up as an extra span in the very next scan, and a flag that is wrongly lost shows up as a missing span. Both are visible within cfg_groups+1 cycles of scan_start. A merge error splits or joins spans, which changes the span list itself. A clear-range error surfaces one scan later, when leftover or lost flags distort the span list. The sweeps check every index-plane pattern of an eight-group screen, and every group pattern of a four-group screen in 24-bit mode with mixed planes. In both sweeps each scan also confirms that the previous one cleared its groups.

// File: rtl/fbdt_pkg.sv
// Package: shared types and constants of the dirty-region tracker.
// Assumes: one index page covers four rows; each wide plane uses four pages per index page.
package fbdt_pkg;
    localparam int SUB_LOG  = 2;   // log2 of wide pages per index page
    localparam int ROW_LOG  = 2;   // log2 of rows per group

    typedef enum logic [1:0] {
        PL_INDEX   = 2'd0,
        PL_DIRECT  = 2'd1,
        PL_CONTROL = 2'd2,
        PL_NONE    = 2'd3
    } plane_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_CLEAR = 2'd2
    } scan_st_e;
endpackage

// File: rtl/fbdt_flag_bank.sv
// Module: a bank of per-page dirty flags with set, set-all and ranged clear.
// Pages written while a scan runs are remembered in a "fresh" mask, and the ranged
// clear spares them, so writes racing a scan are never lost.
// Assumes: the clear range satisfies clr_lo <= clr_hi, and a set wins over a clear.
module fbdt_flag_bank #(
    parameter  int PAGES = 16,
    localparam int PW    = $clog2(PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [PW-1:0]    set_page,
    input  logic             set_all,
    input  logic             track_en,
    input  logic             track_reset,
    input  logic             clr_en,
    input  logic [PW-1:0]    clr_lo,
    input  logic [PW-1:0]    clr_hi,
    output logic [PAGES-1:0] flags
);
    for (genvar i = 0; i < PAGES; i++) begin : g_page
        logic hit;
        logic in_rng;
        logic flag_q;
        logic fresh_q;

        assign hit    = set_all || (set_en && (set_page == PW'(i)));
        assign in_rng = (PW'(i) >= clr_lo) && (PW'(i) <= clr_hi);

        // Page flag: set on write or invalidate, cleared by the ranged clear unless fresh.
        always_ff @(posedge clk) begin
            if (!rst_n)                                flag_q <= 1'b0;
            else if (hit)                              flag_q <= 1'b1;
            else if (clr_en && in_rng && !fresh_q)     flag_q <= 1'b0;
        end

        // Fresh mark: records a write that lands while a scan is running.
        always_ff @(posedge clk) begin
            if (!rst_n || track_reset)                 fresh_q <= 1'b0;
            else if (track_en && hit)                  fresh_q <= 1'b1;
        end

        assign flags[i] = flag_q;
    end

    a_r8_set_all_marks: assert property (@(posedge clk) disable iff (!rst_n)
        set_all |=> (&flags));
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (flags == '0));
endmodule

// File: rtl/fbdt_group_reduce.sv
// Module: combines the per-page flags of all planes into one dirty bit per row group.
// Assumes: wide planes have exactly four pages per group, indexed group*4 + k.
module fbdt_group_reduce import fbdt_pkg::*; #(
    parameter  int GROUPS = 16,
    localparam int WIDE   = GROUPS << SUB_LOG
) (
    input  logic              color24_en,
    input  logic [GROUPS-1:0] idx_flags,
    input  logic [WIDE-1:0]   dir_flags,
    input  logic [WIDE-1:0]   ctl_flags,
    output logic [GROUPS-1:0] group_dirty
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        // Group dirtiness: index page, or in 24-bit mode any of its eight wide pages.
        assign group_dirty[g] = idx_flags[g] ||
            (color24_en && ((|dir_flags[g*(1<<SUB_LOG) +: (1<<SUB_LOG)]) ||
                            (|ctl_flags[g*(1<<SUB_LOG) +: (1<<SUB_LOG)])));
    end
endmodule

// File: rtl/fbdt_scan_seq.sv
// Module: refresh scan sequencer. Visits one group per clock, merges dirty runs into
// registered span records, tracks the lowest/highest dirty group, then requests a
// ranged clear for one cycle and pulses scan_done.
// Assumes: 1 <= cfg_groups <= GROUPS, held stable during a scan.
module fbdt_scan_seq import fbdt_pkg::*; #(
    parameter  int GROUPS = 16,
    localparam int GW     = $clog2(GROUPS),
    localparam int CW     = $clog2(GROUPS + 1),
    localparam int RW     = $clog2((GROUPS << ROW_LOG) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_start,
    input  logic [CW-1:0]     cfg_groups,
    input  logic [GROUPS-1:0] group_dirty,
    output logic              span_valid,
    output logic [RW-1:0]     span_row,
    output logic [RW-1:0]     span_rows,
    output logic              scan_done,
    output logic              busy,
    output logic              scan_begin,
    output logic              clr_en,
    output logic [GW-1:0]     clr_lo,
    output logic [GW-1:0]     clr_hi
);
    scan_st_e      state;
    logic [GW-1:0] g;
    logic [GW-1:0] run_start;
    logic          in_run;
    logic          any_dirty;

    logic          dirty_now;
    logic          last_grp;
    logic [GW-1:0] start_eff;
    logic [CW-1:0] run_len;

    // Current-group decode and span length for a run closing at this group.
    always_comb begin
        dirty_now = group_dirty[g];
        last_grp  = (CW'(g) == (cfg_groups - CW'(1)));
        start_eff = in_run ? run_start : g;
        run_len   = CW'(g) - CW'(start_eff) + (dirty_now ? CW'(1) : CW'(0));
    end

    assign busy       = (state != ST_IDLE);
    assign scan_begin = (state == ST_IDLE) && scan_start;
    assign clr_en     = (state == ST_CLEAR) && any_dirty;

    // Scan state machine with run merging and dirty-range capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            g          <= '0;
            run_start  <= '0;
            in_run     <= 1'b0;
            any_dirty  <= 1'b0;
            clr_lo     <= '0;
            clr_hi     <= '0;
            span_valid <= 1'b0;
            span_row   <= '0;
            span_rows  <= '0;
            scan_done  <= 1'b0;
        end else begin
            span_valid <= 1'b0;
            scan_done  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (scan_start) begin
                        state     <= ST_SCAN;
                        g         <= '0;
                        in_run    <= 1'b0;
                        any_dirty <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (dirty_now) begin
                        in_run <= 1'b1;
                        if (!in_run)    run_start <= g;
                        if (!any_dirty) clr_lo    <= g;
                        clr_hi    <= g;
                        any_dirty <= 1'b1;
                    end
                    if ((!dirty_now && in_run) || (last_grp && dirty_now)) begin
                        span_valid <= 1'b1;
                        span_row   <= RW'({start_eff, 2'b00});
                        span_rows  <= RW'({run_len, 2'b00});
                    end
                    if (!dirty_now) in_run <= 1'b0;
                    if (last_grp) state <= ST_CLEAR;
                    else          g     <= g + GW'(1);
                end
                default: begin
                    state     <= ST_IDLE;
                    scan_done <= 1'b1;
                end
            endcase
        end
    end

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);
    a_r10_span_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        span_valid |-> busy);
    a_r3_span_shape: assert property (@(posedge clk) disable iff (!rst_n)
        span_valid |-> ((span_rows != '0) && (span_rows[1:0] == 2'b00) && (span_row[1:0] == 2'b00)));
    a_r4_span_bound: assert property (@(posedge clk) disable iff (!rst_n)
        span_valid |-> ((int'(span_row) + int'(span_rows)) <= (int'(cfg_groups) * 4)));
endmodule

// File: rtl/fb_dirty_tracker.sv
// Module: top of the framebuffer dirty-region tracker. Decodes host writes into page
// flags of three planes, reduces them to row-group dirtiness and runs the refresh scan.
// Assumes: byte addresses per plane; a page is 2**PAGE_BITS bytes; configuration
// inputs are stable while a scan runs.
module fb_dirty_tracker import fbdt_pkg::*; #(
    parameter  int MAX_GROUPS = 16,
    parameter  int PAGE_BITS  = 12,
    localparam int GW     = $clog2(MAX_GROUPS),
    localparam int PGW    = GW + SUB_LOG,
    localparam int ADDR_W = PGW + PAGE_BITS,
    localparam int CW     = $clog2(MAX_GROUPS + 1),
    localparam int RW     = $clog2((MAX_GROUPS << ROW_LOG) + 1),
    localparam int WIDE   = MAX_GROUPS << SUB_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              color24_en,
    input  logic [CW-1:0]     cfg_groups,
    input  logic              wr_en,
    input  logic [1:0]        wr_plane,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              invalidate,
    input  logic              scan_start,
    output logic              span_valid,
    output logic [RW-1:0]     span_row,
    output logic [RW-1:0]     span_rows,
    output logic              scan_done
);
    plane_e            plane;
    logic [PGW-1:0]    wr_page;
    logic              idx_set, dir_set, ctl_set;
    logic [MAX_GROUPS-1:0] idx_flags, group_dirty;
    logic [WIDE-1:0]   dir_flags, ctl_flags;
    logic              busy, scan_begin, clr_en, wide_clr;
    logic [GW-1:0]     clr_lo, clr_hi;
    logic [PGW-1:0]    wide_lo, wide_hi;

    // Write decode: plane select and index-plane range check.
    always_comb begin
        plane    = plane_e'(wr_plane);
        wr_page  = wr_addr[ADDR_W-1:PAGE_BITS];
        idx_set  = wr_en && (plane == PL_INDEX) && (int'(wr_page) < MAX_GROUPS);
        dir_set  = wr_en && (plane == PL_DIRECT);
        ctl_set  = wr_en && (plane == PL_CONTROL);
        wide_clr = clr_en && color24_en;
        wide_lo  = {clr_lo, {SUB_LOG{1'b0}}};
        wide_hi  = {clr_hi, {SUB_LOG{1'b1}}};
    end

    fbdt_flag_bank #(.PAGES(MAX_GROUPS)) u_idx (
        .clk(clk), .rst_n(rst_n), .set_en(idx_set), .set_page(wr_page[GW-1:0]),
        .set_all(invalidate), .track_en(busy), .track_reset(scan_begin),
        .clr_en(clr_en), .clr_lo(clr_lo), .clr_hi(clr_hi), .flags(idx_flags));

    fbdt_flag_bank #(.PAGES(WIDE)) u_dir (
        .clk(clk), .rst_n(rst_n), .set_en(dir_set), .set_page(wr_page),
        .set_all(invalidate), .track_en(busy), .track_reset(scan_begin),
        .clr_en(wide_clr), .clr_lo(wide_lo), .clr_hi(wide_hi), .flags(dir_flags));

    fbdt_flag_bank #(.PAGES(WIDE)) u_ctl (
        .clk(clk), .rst_n(rst_n), .set_en(ctl_set), .set_page(wr_page),
        .set_all(invalidate), .track_en(busy), .track_reset(scan_begin),
        .clr_en(wide_clr), .clr_lo(wide_lo), .clr_hi(wide_hi), .flags(ctl_flags));

    fbdt_group_reduce #(.GROUPS(MAX_GROUPS)) u_reduce (
        .color24_en(color24_en), .idx_flags(idx_flags), .dir_flags(dir_flags),
        .ctl_flags(ctl_flags), .group_dirty(group_dirty));

    fbdt_scan_seq #(.GROUPS(MAX_GROUPS)) u_seq (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .cfg_groups(cfg_groups),
        .group_dirty(group_dirty), .span_valid(span_valid), .span_row(span_row),
        .span_rows(span_rows), .scan_done(scan_done), .busy(busy),
        .scan_begin(scan_begin), .clr_en(clr_en), .clr_lo(clr_lo), .clr_hi(clr_hi));

    a_r11_plane3_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_plane == 2'd3) && !invalidate) |=>
            ((idx_flags & ~$past(idx_flags)) == '0));
endmodule

// File: tb/tb_fb_dirty_tracker.sv
module tb_fb_dirty_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int G  = 16;
    localparam int WG = G * 4;
    localparam int CW = $clog2(G + 1);
    localparam int RW = $clog2(G * 4 + 1);
    localparam int AW = $clog2(WG) + 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic color24_en = 1'b0;
    logic [CW-1:0] cfg_groups = CW'(8);
    logic wr_en = 1'b0;
    logic [1:0] wr_plane = 2'd0;
    logic [AW-1:0] wr_addr = '0;
    logic invalidate = 1'b0;
    logic scan_start = 1'b0;
    logic span_valid, scan_done;
    logic [RW-1:0] span_row, span_rows;

    fb_dirty_tracker #(.MAX_GROUPS(G), .PAGE_BITS(12)) dut (
        .clk(clk), .rst_n(rst_n), .color24_en(color24_en), .cfg_groups(cfg_groups),
        .wr_en(wr_en), .wr_plane(wr_plane), .wr_addr(wr_addr), .invalidate(invalidate),
        .scan_start(scan_start), .span_valid(span_valid), .span_row(span_row),
        .span_rows(span_rows), .scan_done(scan_done));

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit m_idx [G];
    bit m_dir [WG];
    bit m_ctl [WG];
    int exp_row [G];
    int exp_cnt [G];
    int exp_n, exp_lo, exp_hi;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000) begin
            failures++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", cycles, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < G; i++) m_idx[i] = 1'b0;
        for (int i = 0; i < WG; i++) begin m_dir[i] = 1'b0; m_ctl[i] = 1'b0; end
    endtask

    task automatic write_page(input int plane, input int page, input int off);
        @(negedge clk);
        wr_en = 1'b1;
        wr_plane = 2'(plane);
        wr_addr = AW'(page * 4096 + (off & 12'hfff));
        @(negedge clk);
        wr_en = 1'b0;
        if (plane == 0 && page < G) m_idx[page] = 1'b1;
        if (plane == 1) m_dir[page] = 1'b1;
        if (plane == 2) m_ctl[page] = 1'b1;
    endtask

    task automatic do_invalidate();
        @(negedge clk);
        invalidate = 1'b1;
        @(negedge clk);
        invalidate = 1'b0;
        for (int i = 0; i < G; i++) m_idx[i] = 1'b1;
        for (int i = 0; i < WG; i++) begin m_dir[i] = 1'b1; m_ctl[i] = 1'b1; end
    endtask

    function automatic bit grp_dirty(input int g);
        bit d = m_idx[g];
        if (color24_en)
            for (int k = 0; k < 4; k++) d = d | m_dir[4*g+k] | m_ctl[4*g+k];
        return d;
    endfunction

    task automatic compute_expected();
        bit in_run = 1'b0;
        int st = 0;
        exp_n = 0; exp_lo = -1; exp_hi = -1;
        for (int g = 0; g < int'(cfg_groups); g++) begin
            bit d = grp_dirty(g);
            if (d) begin
                if (exp_lo < 0) exp_lo = g;
                exp_hi = g;
                if (!in_run) st = g;
                in_run = 1'b1;
            end else if (in_run) begin
                exp_row[exp_n] = st * 4; exp_cnt[exp_n] = (g - st) * 4; exp_n++;
                in_run = 1'b0;
            end
        end
        if (in_run) begin
            exp_row[exp_n] = st * 4; exp_cnt[exp_n] = (int'(cfg_groups) - st) * 4; exp_n++;
        end
    endtask

    // Runs one scan and compares its spans; mid_page >= 0 writes that index page
    // and re-pulses scan_start three cycles into the scan (R9, R10).
    task automatic run_scan(input string req, input int mid_page);
        int got = 0;
        int cyc = 0;
        int done_cyc = -1;
        compute_expected();
        @(negedge clk);
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        while (cyc < 100 && done_cyc < 0) begin
            @(negedge clk);
            cyc++;
            if (mid_page >= 0 && cyc == 3) begin
                wr_en = 1'b1; wr_plane = 2'd0; wr_addr = AW'(mid_page * 4096 + 12);
                scan_start = 1'b1;
            end else begin
                wr_en = 1'b0; scan_start = 1'b0;
            end
            if (span_valid) begin
                if (got < exp_n) begin
                    check(int'(span_row) == exp_row[got], req, int'(span_row), exp_row[got]);
                    check(int'(span_rows) == exp_cnt[got], req, int'(span_rows), exp_cnt[got]);
                end
                got++;
            end
            if (scan_done) done_cyc = cyc;
        end
        wr_en = 1'b0; scan_start = 1'b0;
        check(got == exp_n, req, got, exp_n);
        check(done_cyc == int'(cfg_groups) + 1, "R10 done latency", done_cyc, int'(cfg_groups) + 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!scan_done && !span_valid, "R10 single pulse / ignored start",
                  int'(scan_done) + int'(span_valid), 0);
        end
        if (exp_lo >= 0) begin
            for (int g = exp_lo; g <= exp_hi; g++) begin
                m_idx[g] = 1'b0;
                if (color24_en)
                    for (int k = 0; k < 4; k++) begin m_dir[4*g+k] = 1'b0; m_ctl[4*g+k] = 1'b0; end
            end
        end
        if (mid_page >= 0) m_idx[mid_page] = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: reset state at the ports and an empty first scan
        check(!span_valid && !scan_done, "R1 outputs after reset", int'(span_valid) + int'(scan_done), 0);
        run_scan("R1 empty scan", -1);
        do_invalidate();
        do_reset();
        run_scan("R1 reset clears invalidate", -1);

        // R2 R3 R6: every index pattern over an 8-group screen
        cfg_groups = CW'(8);
        for (int pat = 0; pat < 256; pat++) begin
            for (int g = 0; g < 8; g++)
                if (pat[g]) write_page(0, g, pat * 37 + g * 5);
            run_scan("R3 sweep index", -1);
        end
        write_page(0, 3, 100);
        run_scan("R2 single group", -1);
        run_scan("R6 second scan empty", -1);

        // R4: run reaching the last configured group
        cfg_groups = CW'(5);
        write_page(0, 3, 0);
        write_page(0, 4, 0);
        run_scan("R4 run to end", -1);

        // R7: out-of-screen flag survives, shows after resize
        cfg_groups = CW'(4);
        write_page(0, 6, 8);
        write_page(0, 1, 8);
        run_scan("R7 small screen", -1);
        cfg_groups = CW'(8);
        run_scan("R7 enlarged screen", -1);

        // R11: inert writes
        write_page(3, 2, 0);
        write_page(0, G, 0);
        run_scan("R11 ignored writes", -1);

        // R8: invalidate in 8-bit mode
        cfg_groups = CW'(6);
        do_invalidate();
        run_scan("R8 full redraw", -1);
        run_scan("R8 clean after redraw", -1);

        // R9: write to a passed group during a scan, plus start pulse mid-scan
        cfg_groups = CW'(8);
        write_page(0, 0, 4);
        write_page(0, 5, 4);
        run_scan("R9 scan with race", 1);
        run_scan("R9 raced group reported", -1);
        run_scan("R9 then clean", -1);

        // R5: wide-plane writes are inert in 8-bit mode
        write_page(1, 9, 0);
        write_page(2, 22, 0);
        run_scan("R5 wide planes ignored in 8-bit", -1);

        // R5: 24-bit mode sweep over a 4-group screen with mixed planes
        color24_en = 1'b1;
        do_reset();
        cfg_groups = CW'(4);
        for (int pat = 0; pat < 256; pat++) begin
            for (int g = 0; g < 4; g++) begin
                if (pat[g]) begin
                    int pl = ((pat >> 4) + g) % 3;
                    int pg = (pl == 0) ? g : (4 * g + (((pat >> 6) + g) % 4));
                    write_page(pl, pg, pat);
                end
            end
            run_scan("R5 sweep 24-bit", -1);
        end

        // R8: invalidate in 24-bit mode, wide planes cleared too
        cfg_groups = CW'(7);
        do_invalidate();
        run_scan("R8 full redraw 24-bit", -1);
        run_scan("R8 clean 24-bit", -1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule